// File: doc/BRIEF.md
# Multiplexed External Memory Bus Sequencer

This block drives the control strobes of an external memory bus whose low address and data share one 8-bit set of lines, while the upper address bits have their own port. One clock period of the block is one oscillator period, and six periods form one machine cycle. A code fetch takes one machine cycle. An external data read or write takes two. In every access an address-latch pulse marks the start, and the low address is on the shared lines while that pulse is high. After the pulse the sequencer issues a program-store strobe for external fetches, or a read or write strobe for data accesses. Data read from the bus appears on `rdata` together with a one-cycle `done` pulse.

Fetches whose address lies below the internal code limit never reach the bus. Outside accesses, the address-latch pin keeps pulsing once per machine cycle. A quiet-mode input silences this idle toggling to lower emissions. The quiet value is taken only at machine-cycle boundaries, and it has no effect during external fetches and data accesses, which always pulse the latch.

Requests are offered with `req_valid`. The block takes one only on a clock edge where `req_ready` is high. That happens in the last period of an idle machine cycle, so every access starts on a cycle boundary.

Top module: `msq_bus_seq`

## Requirements
- R1: Steps are numbered 0 to 5 within a machine cycle. With quiet mode off, `ale` is high in steps 0 and 1 and low in steps 2 to 5, whether the block is idle or doing an internal fetch. This gives a pulse two periods wide every six periods.
- R2: In steps 0 to 2 of an external access, `ad_out` carries the low address byte and `ad_oe` is 1. For the whole external access, `a_hi` carries the upper address bits.
- R3: An external fetch uses `req_kind` 2'b00 with an address at or above INT_CODE_LIMIT. It drives `psen_n` low in steps 3 to 5 and releases the shared lines in those steps. `ad_in` is sampled in step 5.
- R4: A fetch below INT_CODE_LIMIT takes one machine cycle. During it `psen_n` stays high and `ad_oe` stays 0, and `rdata` does not change.
- R5: A data read uses `req_kind` 2'b01 and lasts twelve periods. `rd_n` is low in steps 5 to 10 and `ad_oe` is 0 in steps 3 to 11. `ad_in` is sampled in step 10.
- R6: A data write uses `req_kind` 2'b10 or 2'b11 and lasts twelve periods. `wr_n` is low in steps 5 to 10, and `ad_out` carries the write data with `ad_oe` high in steps 3 to 11.
- R7: In a data access the second machine cycle has no address-latch pulse, so `ale` is low in steps 2 to 11.
- R8: When `ale_quiet` is 1 at a cycle boundary, `ale` stays low for the next idle or internal-fetch machine cycle. External accesses still pulse `ale` in steps 0 and 1.
- R9: `req_ready` is 1 only in the last period of an idle machine cycle. A `req_valid` held at any other time, including during an access, is ignored and does not disturb the access in progress.
- R10: `done` is high for exactly one period, the one after an access's last step. In that same period `rdata` holds the sampled byte.
- R11: While reset is held, `ale` is 0, all three strobes are high, and `ad_oe`, `done` and `req_ready` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ale_quiet | input | 1 | Silence idle address-latch pulses |
| req_valid | input | 1 | Access request present |
| req_kind | input | 2 | 00 fetch, 01 read, 1x write |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Request accepted at this edge if valid |
| ale | output | 1 | Address-latch enable |
| psen_n | output | 1 | Program-store enable, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| ad_out | output | 8 | Shared address/data lines, outgoing value |
| ad_oe | output | 1 | Shared lines driven when 1 |
| ad_in | input | 8 | Shared address/data lines, incoming value |
| a_hi | output | 8 | Upper address port |
| rdata | output | 8 | Last byte sampled from the bus |
| done | output | 1 | End-of-access pulse |

## Verification
A random stream mixes fetches, reads and writes with random addresses and a random quiet setting. Both sides of the internal code limit get hit, and the three access shapes are told apart step by step. The incoming bus byte is changed every period, so a sample taken one step early or late returns the wrong value. In directed runs a request is held high throughout an access to show it is ignored. The bench also watches idle cycles with quiet mode on and off, and tries the addresses just below and just at the internal code limit.

// File: rtl/msq_pkg.sv
package msq_pkg;

  typedef enum logic [1:0] {
    ACC_INT   = 2'd0,
    ACC_FETCH = 2'd1,
    ACC_READ  = 2'd2,
    ACC_WRITE = 2'd3
  } acc_e;

  localparam int STEP_W = 4;

  localparam logic [STEP_W-1:0] ST_CYC_LAST   = 4'd5;
  localparam logic [STEP_W-1:0] ST_DATA_LAST  = 4'd11;
  localparam logic [STEP_W-1:0] ST_ALE_END    = 4'd2;
  localparam logic [STEP_W-1:0] ST_ADDR_END   = 4'd3;
  localparam logic [STEP_W-1:0] ST_PSEN_FIRST = 4'd3;
  localparam logic [STEP_W-1:0] ST_PSEN_LAST  = 4'd5;
  localparam logic [STEP_W-1:0] ST_XS_FIRST   = 4'd5;
  localparam logic [STEP_W-1:0] ST_XS_LAST    = 4'd10;

  function automatic logic is_data(acc_e k);
    return (k == ACC_READ) || (k == ACC_WRITE);
  endfunction

endpackage

// File: rtl/msq_stepper.sv
module msq_stepper
  import msq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  acc_e              start_kind,
  input  logic              quiet_in,
  output logic [STEP_W-1:0] step,
  output logic              busy,
  output acc_e              kind,
  output logic              quiet_q,
  output logic              ready,
  output logic              done
);

  logic [STEP_W-1:0] step_nx;
  logic [STEP_W-1:0] last_step;
  logic              at_end;
  logic              busy_nx;
  acc_e              kind_nx;
  logic              quiet_nx;
  logic              done_nx;

  always_comb begin
    last_step = (busy && is_data(kind)) ? ST_DATA_LAST : ST_CYC_LAST;
    at_end    = (step == last_step);
    step_nx   = at_end ? '0 : step + 1'b1;
    busy_nx   = busy;
    kind_nx   = kind;
    if (start) begin
      busy_nx = 1'b1;
      kind_nx = start_kind;
    end else if (busy && at_end) begin
      busy_nx = 1'b0;
    end
    quiet_nx = at_end ? quiet_in : quiet_q;
    done_nx  = busy && at_end;
  end

  assign ready = !busy && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step    <= '0;
      busy    <= 1'b0;
      kind    <= ACC_INT;
      quiet_q <= 1'b1;
      done    <= 1'b0;
    end else begin
      step    <= step_nx;
      busy    <= busy_nx;
      kind    <= kind_nx;
      quiet_q <= quiet_nx;
      done    <= done_nx;
    end
  end

endmodule

// File: rtl/msq_strobes.sv
module msq_strobes
  import msq_pkg::*;
(
  input  logic [STEP_W-1:0] step,
  input  logic              busy,
  input  acc_e              kind,
  input  logic              quiet_q,
  output logic              ale,
  output logic              psen_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic              ad_oe,
  output logic              addr_phase,
  output logic              sample
);

  logic ext;
  logic in_psen;
  logic in_xs;

  always_comb begin
    ext        = busy && (kind != ACC_INT);
    in_psen    = (step >= ST_PSEN_FIRST) && (step <= ST_PSEN_LAST);
    in_xs      = (step >= ST_XS_FIRST) && (step <= ST_XS_LAST);
    addr_phase = (step < ST_ADDR_END);
    ale        = (step < ST_ALE_END) && (ext || !quiet_q);
    psen_n     = !(ext && (kind == ACC_FETCH) && in_psen);
    rd_n       = !(ext && (kind == ACC_READ) && in_xs);
    wr_n       = !(ext && (kind == ACC_WRITE) && in_xs);
    ad_oe      = ext && (addr_phase || (kind == ACC_WRITE));
    sample     = ext && (((kind == ACC_FETCH) && (step == ST_PSEN_LAST)) ||
                         ((kind == ACC_READ) && (step == ST_XS_LAST)));
  end

endmodule

// File: rtl/msq_datapath.sv
module msq_datapath #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] wdata_in,
  input  logic          addr_phase,
  input  logic          sample,
  input  logic [DW-1:0] ad_in,
  output logic [DW-1:0] ad_out,
  output logic [AW-DW-1:0] a_hi,
  output logic [DW-1:0] rdata
);

  logic [AW-1:0] addr_q;
  logic [AW-1:0] addr_nx;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] wdata_nx;
  logic [DW-1:0] rdata_nx;

  always_comb begin
    addr_nx  = load ? addr_in : addr_q;
    wdata_nx = load ? wdata_in : wdata_q;
    rdata_nx = sample ? ad_in : rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata   <= '0;
    end else begin
      addr_q  <= addr_nx;
      wdata_q <= wdata_nx;
      rdata   <= rdata_nx;
    end
  end

  assign ad_out = addr_phase ? addr_q[DW-1:0] : wdata_q;
  assign a_hi   = addr_q[AW-1:DW];

endmodule

// File: rtl/msq_bus_seq.sv
module msq_bus_seq
  import msq_pkg::*;
#(
  parameter int AW             = 16,
  parameter int DW             = 8,
  parameter int INT_CODE_LIMIT = 16384
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ale_quiet,
  input  logic             req_valid,
  input  logic [1:0]       req_kind,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  output logic             req_ready,
  output logic             ale,
  output logic             psen_n,
  output logic             rd_n,
  output logic             wr_n,
  output logic [DW-1:0]    ad_out,
  output logic             ad_oe,
  input  logic [DW-1:0]    ad_in,
  output logic [AW-DW-1:0] a_hi,
  output logic [DW-1:0]    rdata,
  output logic             done
);

  localparam logic [AW:0] LIMIT = (AW+1)'(INT_CODE_LIMIT);

  logic rst_meta_n;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  logic              start;
  acc_e              start_kind;
  logic [STEP_W-1:0] step;
  logic              busy;
  acc_e              kind;
  logic              quiet_q;
  logic              addr_phase;
  logic              sample;

  always_comb begin
    start = req_valid && req_ready;
    if (req_kind[1])
      start_kind = ACC_WRITE;
    else if (req_kind[0])
      start_kind = ACC_READ;
    else if ({1'b0, req_addr} < LIMIT)
      start_kind = ACC_INT;
    else
      start_kind = ACC_FETCH;
  end

  msq_stepper u_stepper (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start      (start),
    .start_kind (start_kind),
    .quiet_in   (ale_quiet),
    .step       (step),
    .busy       (busy),
    .kind       (kind),
    .quiet_q    (quiet_q),
    .ready      (req_ready),
    .done       (done)
  );

  msq_strobes u_strobes (
    .step       (step),
    .busy       (busy),
    .kind       (kind),
    .quiet_q    (quiet_q),
    .ale        (ale),
    .psen_n     (psen_n),
    .rd_n       (rd_n),
    .wr_n       (wr_n),
    .ad_oe      (ad_oe),
    .addr_phase (addr_phase),
    .sample     (sample)
  );

  msq_datapath #(.AW(AW), .DW(DW)) u_datapath (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .load       (start),
    .addr_in    (req_addr),
    .wdata_in   (req_wdata),
    .addr_phase (addr_phase),
    .sample     (sample),
    .ad_in      (ad_in),
    .ad_out     (ad_out),
    .a_hi       (a_hi),
    .rdata      (rdata)
  );

endmodule

// File: rtl/msq_bus_seq_chk.sv
module msq_bus_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic ale,
  input logic psen_n,
  input logic rd_n,
  input logic wr_n,
  input logic ad_oe,
  input logic req_ready,
  input logic done
);

  p_ale_width_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale) |-> $past(ale, 2));

  p_psen_after_ale_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(psen_n) |-> ($past(ale, 2) && !$past(ale, 1)));

  p_psen_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(psen_n) |-> (!$past(psen_n, 3) && $past(psen_n, 4)));

  p_fetch_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !psen_n |-> !ad_oe);

  p_read_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);

  p_rd_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_n) |-> (!$past(rd_n, 6) && $past(rd_n, 7)));

  p_wr_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> (!$past(wr_n, 6) && $past(wr_n, 7)));

  p_write_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> ad_oe);

  p_no_ale_in_xs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> !ale);

  p_one_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({!psen_n, !rd_n, !wr_n}) <= 1);

  p_ready_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (psen_n && rd_n && wr_n && !ad_oe));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind msq_bus_seq msq_bus_seq_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ale       (ale),
  .psen_n    (psen_n),
  .rd_n      (rd_n),
  .wr_n      (wr_n),
  .ad_oe     (ad_oe),
  .req_ready (req_ready),
  .done      (done)
);

// File: tb/test_msq_bus_seq.sv
`timescale 1ns/100ps
module test_msq_bus_seq;

  logic        clk;
  logic        rst_n;
  logic        ale_quiet;
  logic        req_valid;
  logic [1:0]  req_kind;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata;
  logic        req_ready;
  logic        ale, psen_n, rd_n, wr_n;
  logic [7:0]  ad_out;
  logic        ad_oe;
  logic [7:0]  ad_in;
  logic [7:0]  a_hi;
  logic [7:0]  rdata;
  logic        done;

  int  n_chk;
  int  n_bad;
  bit  finished;
  logic [7:0] rd_model;

  msq_bus_seq i_msq_bus_seq (
    .clk(clk), .rst_n(rst_n), .ale_quiet(ale_quiet), .req_valid(req_valid),
    .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
    .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .a_hi(a_hi),
    .rdata(rdata), .done(done)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // expected values by step t; k: 0 fetch, 1 read, 2 write; intl: internal or idle
  function automatic bit e_ale(int t, bit intl, bit q);
    return (t < 2) && (!intl || !q);
  endfunction
  function automatic bit e_psen_n(int k, bit intl, int t);
    return !(k == 0 && !intl && t >= 3 && t <= 5);
  endfunction
  function automatic bit e_rd_n(int k, int t);
    return !(k == 1 && t >= 5 && t <= 10);
  endfunction
  function automatic bit e_wr_n(int k, int t);
    return !(k == 2 && t >= 5 && t <= 10);
  endfunction
  function automatic bit e_oe(int k, bit intl, int t);
    return !intl && ((t < 3) || (k == 2));
  endfunction

  task automatic wait_ready();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
  endtask

  task automatic do_access(input int k, input logic [15:0] a, input logic [7:0] w,
                           input bit q, input bit stress);
    bit intl;
    int len;
    intl = (k == 0) && (a < 16'd16384);
    len  = (k == 0) ? 6 : 12;
    ale_quiet = q;
    req_valid = 1'b1;
    req_kind  = (k == 2) ? 2'(2 + ($urandom % 2)) : 2'(k);
    req_addr  = a;
    req_wdata = w;
    wait_ready();
    for (int t = 0; t < len; t++) begin
      @(negedge clk);
      if (t == 0) begin
        req_valid = stress;
        req_kind  = 2'($urandom % 4);
        req_addr  = 16'($urandom);
        req_wdata = 8'($urandom);
      end
      chk(ale == e_ale(t, intl, q), (k == 0) ? "R1/R8 ale fetch" : "R7/R8 ale data", ale, e_ale(t, intl, q));
      chk(psen_n == e_psen_n(k, intl, t), intl ? "R4 psen internal" : "R3 psen", psen_n, e_psen_n(k, intl, t));
      chk(rd_n == e_rd_n(k, t), "R5 rd_n", rd_n, e_rd_n(k, t));
      chk(wr_n == e_wr_n(k, t), "R6 wr_n", wr_n, e_wr_n(k, t));
      chk(ad_oe == e_oe(k, intl, t), "R2/R3/R5/R6 ad_oe", ad_oe, e_oe(k, intl, t));
      if (ad_oe && t < 3)
        chk(ad_out == a[7:0], "R2 low address", ad_out, a[7:0]);
      if (ad_oe && t >= 3)
        chk(ad_out == w, "R6 write data", ad_out, w);
      if (!intl)
        chk(a_hi == a[15:8], "R2 high address", a_hi, a[15:8]);
      chk(!done && !req_ready, "R9/R10 busy flags", {done, req_ready}, 0);
      ad_in = 8'($urandom);
      if ((k == 0 && !intl && t == 5) || (k == 1 && t == 10))
        rd_model = ad_in;
    end
    @(negedge clk);
    chk(done == 1'b1, "R10 done pulse", done, 1);
    chk(rdata == rd_model, intl ? "R4 rdata kept" : "R10 rdata", rdata, rd_model);
  endtask

  task automatic idle_watch(input bit q);
    req_valid = 1'b0;
    ale_quiet = q;
    wait_ready();
    for (int t = 0; t < 6; t++) begin
      @(negedge clk);
      chk(ale == e_ale(t, 1'b1, q), q ? "R8 idle quiet" : "R1 idle ale", ale, e_ale(t, 1'b1, q));
      chk(psen_n && rd_n && wr_n && !ad_oe, "R9 idle strobes", {psen_n, rd_n, wr_n, ad_oe}, 4'b1110);
      chk(req_ready == (t == 5), "R9 ready timing", req_ready, t == 5);
      chk(!done, "R10 no done idle", done, 0);
    end
  endtask

  initial begin
    finished = 1'b0;
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; ale_quiet = 1'b1; req_valid = 1'b0; req_kind = 2'b00;
    req_addr = '0; req_wdata = '0; ad_in = '0; rd_model = '0;
    repeat (3) @(negedge clk);
    chk(!ale && psen_n && rd_n && wr_n, "R11 reset strobes", {ale, psen_n, rd_n, wr_n}, 4'b0111);
    chk(!ad_oe && !done && !req_ready, "R11 reset flags", {ad_oe, done, req_ready}, 0);
    chk(rdata == 8'h00, "R11 reset rdata", rdata, 0);
    rst_n = 1'b1;

    idle_watch(1'b0);
    idle_watch(1'b1);
    // directed: code limit boundary, both quiet settings
    do_access(0, 16'h3FFF, 8'h00, 1'b0, 1'b0);
    do_access(0, 16'h3FFF, 8'h00, 1'b1, 1'b0);
    do_access(0, 16'h4000, 8'h00, 1'b1, 1'b0);
    do_access(1, 16'h0012, 8'h00, 1'b1, 1'b0);
    do_access(2, 16'hABCD, 8'h5A, 1'b1, 1'b0);
    // request held during accesses must be ignored
    do_access(1, 16'h8001, 8'h00, 1'b0, 1'b1);
    do_access(2, 16'h1234, 8'hC3, 1'b1, 1'b1);
    do_access(0, 16'hFFFF, 8'h00, 1'b0, 1'b1);
    for (int i = 0; i < 80; i++)
      do_access($urandom % 3, 16'($urandom), 8'($urandom), 1'($urandom), 1'($urandom));
    idle_watch(1'b1);
    idle_watch(1'b0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule